// File: doc/BRIEF.md
# Two-Phase Scan Memory Loader

This block takes 32-bit words, each with a target address, from a valid/ready stream. It moves each word into an on-chip memory through a serial scan chain. The chain is clocked by two non-overlapping phases. The block makes the serial data bit, both phases, a commit strobe and a read/write select from one fast system clock. Each accepted word becomes one frame of `FRAME_LEN` scan cycles, and words are framed in arrival order. One scan cycle is four steps: a gap with both phases low, phase 1 high, a second gap, then phase 2 high. A programmable divider sets how many system clocks each step lasts.

While loading, the block holds the processor in reset. The word that carries the `last` flag releases reset when its frame completes, and a one-cycle done pulse marks that point. A read request produces a read frame. During a read frame the mode select is high, and the block gathers the bits that the chain returns on its scan-out pin during the closing 32 scan cycles. The gathered word is presented with a one-cycle valid pulse, so it can be compared against an expected value.

Top module: `scan_loader`

## Requirements
- R1: Every scan cycle runs four steps in a fixed order. Step 0 has both phases low, step 1 has `sc_ph1` high, step 2 has both low, and step 3 has `sc_ph2` high. `sc_ph1` and `sc_ph2` are never high together.
- R2: Each step lasts `div_cfg` system clocks, and a value of 0 counts as 1. `div_cfg` is sampled when a word is accepted and holds for that whole frame.
- R3: A frame has exactly `FRAME_LEN` scan cycles, 496 by default. Scan cycle k carries frame bit `FRAME_LEN-1-k`. Frame bits 31..0 are the data word, bits 63..32 are the address, and all higher bits are 0.
- R4: `sc_din` changes only in step 0 of a scan cycle, and it is 0 while idle.
- R5: `sc_upd` is high for all four steps of the final scan cycle of a frame and low at all other times.
- R6: `in_ready` is high while idle. It is low from the clock edge that accepts a word until the frame's last step ends. Each accepted word produces exactly one frame, in arrival order.
- R7: `sc_rdmode` is high for every step of a frame whose word arrived with `in_read`=1, and low during write frames and while idle.
- R8: In a read frame, `sc_ret` is sampled in the last system clock of step 3 of each of the final 32 scan cycles. The first sample becomes bit 31 of `rd_data`. `rd_valid` pulses for one cycle when the frame ends, which is the same cycle in which `in_ready` returns high, and `rd_data` holds the word at that point.
- R9: `core_rst_n` is low out of reset and drops when any word is accepted. It rises when a frame whose word had `in_last`=1 ends, and `done` pulses high for that one cycle.
- R10: During and right after reset, `in_ready` is 1, and all scan pins, `rd_valid`, `done` and `core_rst_n` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | DIV_W (8) | System clocks per step, 0 treated as 1 |
| in_valid | input | 1 | Word request valid |
| in_ready | output | 1 | Loader idle and able to take a word |
| in_addr | input | ADDR_W (32) | Target memory address |
| in_data | input | DATA_W (32) | Word to write |
| in_read | input | 1 | 1 requests a read-back frame |
| in_last | input | 1 | Final word of the load sequence |
| sc_din | output | 1 | Serial scan data to the chain |
| sc_ph1 | output | 1 | Scan clock phase 1 |
| sc_ph2 | output | 1 | Scan clock phase 2 |
| sc_upd | output | 1 | Commit strobe in a frame's final scan cycle |
| sc_rdmode | output | 1 | Read (1) / write (0) select for the frame |
| sc_ret | input | 1 | Serial data returned from the chain |
| rd_data | output | DATA_W (32) | Word gathered in a read frame |
| rd_valid | output | 1 | One-cycle pulse when rd_data is fresh |
| core_rst_n | output | 1 | Active-low reset held on the processor |
| done | output | 1 | One-cycle pulse when loading ends |

## Verification
The bound checker watches several properties on every cycle: that the phases never overlap, that phase 1 falls into a gap, that the data bit holds while either phase is high, that the commit strobe begins in a gap, that ready and the processor reset stay low while a frame is on the pins, and that done and the read valid are single-cycle pulses. The bench compares every system clock of each frame against a pin pattern it computes itself, using several divider settings and both frame kinds. Only the bench can show the exact step lengths, the bit order of address and data, the frame length, the reset release following the `last` flag, and the gathered read word.

// File: rtl/scan_loader_pkg.sv
package scan_loader_pkg;
  // Position inside one scan cycle; the order is the phase sequence.
  typedef enum logic [1:0] {
    STEP_GAP_A = 2'd0,
    STEP_PH1   = 2'd1,
    STEP_GAP_B = 2'd2,
    STEP_PH2   = 2'd3
  } step_e;
endpackage

// File: rtl/scan_step_gen.sv
module scan_step_gen
  import scan_loader_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output step_e            step,
  output logic             step_last
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim_m1;
  step_e            step_q, step_d;

  assign lim_m1    = (div == '0) ? '0 : div - 1'b1;
  assign step_last = run && (cnt_q == lim_m1);
  assign step      = step_q;

  always_comb begin
    cnt_d  = cnt_q;
    step_d = step_q;
    if (!run) begin
      cnt_d  = '0;
      step_d = STEP_GAP_A;
    end else if (step_last) begin
      cnt_d  = '0;
      step_d = step_e'(step_q + 2'd1);
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      step_q <= STEP_GAP_A;
    end else begin
      cnt_q  <= cnt_d;
      step_q <= step_d;
    end
  end
endmodule

// File: rtl/scan_frame_ctrl.sv
module scan_frame_ctrl
  import scan_loader_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int FRAME_LEN = 496,
  parameter int DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_read,
  input  logic              in_last,
  input  logic [DIV_W-1:0]  div_cfg,
  input  step_e             step,
  input  logic              step_last,
  output logic              run,
  output logic [DIV_W-1:0]  div_q,
  output logic              sc_din,
  output logic              sc_upd,
  output logic              sc_rdmode,
  input  logic              sc_ret,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              core_rst_n,
  output logic              done
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_CAP  = IDX_W'(FRAME_LEN - DATA_W);

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d, pos;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d, rsh_q, rsh_d;
  logic              read_q, read_d, last_q, last_d;
  logic [DIV_W-1:0]  div_d;
  logic              rdv_q, rdv_d, core_q, core_d, done_q, done_d;
  logic              accept, cyc_end, frame_end, cap, fbit;

  assign accept    = in_valid && !busy_q;
  assign cyc_end   = busy_q && step_last && (step == STEP_PH2);
  assign frame_end = cyc_end && (idx_q == IDX_LAST);
  assign cap       = cyc_end && read_q && (idx_q >= IDX_CAP);
  assign pos       = IDX_LAST - idx_q;

  // Frame bit for the current scan cycle: data low, address above, zeros beyond.
  always_comb begin
    fbit = 1'b0;
    for (int k = 0; k < DATA_W; k++)
      if (pos == IDX_W'(k)) fbit = data_q[k];
    for (int k = 0; k < ADDR_W; k++)
      if (pos == IDX_W'(DATA_W + k)) fbit = addr_q[k];
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    addr_d = addr_q;
    data_d = data_q;
    read_d = read_q;
    last_d = last_q;
    div_d  = div_q;
    rsh_d  = rsh_q;
    core_d = core_q;
    rdv_d  = frame_end && read_q;
    done_d = frame_end && last_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
      addr_d = in_addr;
      data_d = in_data;
      read_d = in_read;
      last_d = in_last;
      div_d  = div_cfg;
      core_d = 1'b0;
    end else if (cyc_end) begin
      if (cap) rsh_d = {rsh_q[DATA_W-2:0], sc_ret};
      if (frame_end) begin
        busy_d = 1'b0;
        if (last_q) core_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      read_q <= 1'b0;
      last_q <= 1'b0;
      div_q  <= '0;
      rsh_q  <= '0;
      rdv_q  <= 1'b0;
      core_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      addr_q <= addr_d;
      data_q <= data_d;
      read_q <= read_d;
      last_q <= last_d;
      div_q  <= div_d;
      rsh_q  <= rsh_d;
      rdv_q  <= rdv_d;
      core_q <= core_d;
      done_q <= done_d;
    end
  end

  assign in_ready   = !busy_q;
  assign run        = busy_q;
  assign sc_din     = busy_q && fbit;
  assign sc_upd     = busy_q && (idx_q == IDX_LAST);
  assign sc_rdmode  = busy_q && read_q;
  assign rd_data    = rsh_q;
  assign rd_valid   = rdv_q;
  assign core_rst_n = core_q;
  assign done       = done_q;
endmodule

// File: rtl/scan_loader.sv
module scan_loader
  import scan_loader_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int FRAME_LEN = 496,
  parameter int DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_read,
  input  logic              in_last,
  output logic              sc_din,
  output logic              sc_ph1,
  output logic              sc_ph2,
  output logic              sc_upd,
  output logic              sc_rdmode,
  input  logic              sc_ret,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              core_rst_n,
  output logic              done
);
  step_e            step;
  logic             step_last, run;
  logic [DIV_W-1:0] div_q;

  scan_step_gen #(.DIV_W(DIV_W)) i_step (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q),
    .step(step), .step_last(step_last)
  );

  scan_frame_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAME_LEN(FRAME_LEN), .DIV_W(DIV_W)
  ) i_frame (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_data(in_data), .in_read(in_read), .in_last(in_last),
    .div_cfg(div_cfg), .step(step), .step_last(step_last),
    .run(run), .div_q(div_q),
    .sc_din(sc_din), .sc_upd(sc_upd), .sc_rdmode(sc_rdmode),
    .sc_ret(sc_ret), .rd_data(rd_data), .rd_valid(rd_valid),
    .core_rst_n(core_rst_n), .done(done)
  );

  assign sc_ph1 = run && (step == STEP_PH1);
  assign sc_ph2 = run && (step == STEP_PH2);
endmodule

// File: rtl/scan_loader_chk.sv
module scan_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic sc_din,
  input logic sc_ph1,
  input logic sc_ph2,
  input logic sc_upd,
  input logic sc_rdmode,
  input logic rd_valid,
  input logic core_rst_n,
  input logic done
);
  assert_phase_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sc_ph1 && sc_ph2));

  assert_ph1_falls_to_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sc_ph1) |-> !sc_ph2);

  assert_din_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_ph1 || sc_ph2) |-> $stable(sc_din));

  assert_upd_starts_in_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sc_upd) |-> (!sc_ph1 && !sc_ph2));

  assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_ph1 || sc_ph2 || sc_upd || sc_rdmode || sc_din) |-> !in_ready);

  assert_core_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !core_rst_n);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (core_rst_n && in_ready));

  assert_rdvalid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (in_ready && !sc_din && !sc_ph1 && !sc_ph2 &&
        !sc_upd && !sc_rdmode && !rd_valid && !core_rst_n && !done);
    end
  end
endmodule

bind scan_loader scan_loader_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .sc_din(sc_din),
  .sc_ph1(sc_ph1), .sc_ph2(sc_ph2), .sc_upd(sc_upd), .sc_rdmode(sc_rdmode),
  .rd_valid(rd_valid), .core_rst_n(core_rst_n), .done(done)
);

// File: tb/test_scan_loader.sv
`timescale 1ns/1ps
module test_scan_loader;
  localparam int FL = 496;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  div_cfg;
  logic        in_valid, in_read, in_last, sc_ret;
  logic [31:0] in_addr, in_data;
  logic        in_ready, sc_din, sc_ph1, sc_ph2, sc_upd, sc_rdmode;
  logic [31:0] rd_data;
  logic        rd_valid, core_rst_n, done;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  scan_loader i_scan_loader (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .in_read(in_read), .in_last(in_last), .sc_din(sc_din), .sc_ph1(sc_ph1),
    .sc_ph2(sc_ph2), .sc_upd(sc_upd), .sc_rdmode(sc_rdmode), .sc_ret(sc_ret),
    .rd_data(rd_data), .rd_valid(rd_valid), .core_rst_n(core_rst_n), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit frame_bit(input [31:0] a, input [31:0] d, input int cyc);
    int p = FL - 1 - cyc;
    if (p < 32) return d[p];
    if (p < 64) return a[p - 32];
    return 1'b0;
  endfunction

  // One frame; every system clock of the frame is compared to a computed pattern.
  task automatic do_frame(input [31:0] a, input [31:0] d, input bit rd, input bit lst,
                          input [7:0] dv, input [31:0] ret);
    int lim = (dv == 0) ? 1 : int'(dv);
    int n_tot = FL * 4 * lim;
    int e_ph = 0, e_din = 0, e_upd = 0, e_mode = 0, e_rdy = 0, e_core = 0;
    @(negedge clk);
    in_addr = a; in_data = d; in_read = rd; in_last = lst; div_cfg = dv;
    in_valid = 1'b1;
    chk(in_ready, "R6 idle ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0; div_cfg = 8'd7;
    for (int n = 0; n < n_tot; n++) begin
      int cyc = n / (4 * lim);
      int stp = (n / lim) % 4;
      if (sc_ph1 !== (stp == 1) || sc_ph2 !== (stp == 3)) e_ph++;
      if (sc_din !== frame_bit(a, d, cyc)) e_din++;
      if (sc_upd !== (cyc == FL - 1)) e_upd++;
      if (sc_rdmode !== rd) e_mode++;
      if (in_ready !== 1'b0 || rd_valid !== 1'b0) e_rdy++;
      if (core_rst_n !== 1'b0 || done !== 1'b0) e_core++;
      sc_ret = (rd && cyc >= FL - 32) ? ret[FL - 1 - cyc] : 1'b0;
      @(negedge clk);
    end
    sc_ret = 1'b0;
    chk(e_ph == 0,   "R1 R2 phase/step timing mismatches", e_ph, 0);
    chk(e_din == 0,  "R3 R4 scan data mismatches", e_din, 0);
    chk(e_upd == 0,  "R5 commit strobe mismatches", e_upd, 0);
    chk(e_mode == 0, "R7 mode select mismatches", e_mode, 0);
    chk(e_rdy == 0,  "R6 ready/valid during frame", e_rdy, 0);
    chk(e_core == 0, "R9 core reset held during frame", e_core, 0);
    chk(in_ready && !sc_ph1 && !sc_ph2 && !sc_upd && !sc_din && !sc_rdmode,
        "R6 frame end returns to idle", in_ready, 1);
    chk(rd_valid == rd, "R8 rd_valid at frame end", rd_valid, rd);
    if (rd) chk(rd_data == ret, "R8 gathered read word", rd_data, ret);
    chk(done == lst, "R9 done pulse", done, lst);
    chk(core_rst_n == lst, "R9 core reset release", core_rst_n, lst);
    @(negedge clk);
    chk(!done && !rd_valid, "R8 R9 single-cycle pulses", {done, rd_valid}, 0);
    chk(core_rst_n == lst, "R9 core reset level holds", core_rst_n, lst);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      bad++; total++;
      $display("FAIL R6 watchdog: actual=hang expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_read = 1'b0; in_last = 1'b0;
    in_addr = '0; in_data = '0; div_cfg = 8'd1; sc_ret = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready && !sc_din && !sc_ph1 && !sc_ph2 && !sc_upd && !sc_rdmode &&
        !rd_valid && !core_rst_n && !done, "R10 state in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !sc_ph1 && !sc_ph2 && !core_rst_n && !done,
        "R10 state after reset", core_rst_n, 0);

    do_frame(32'h0000_0010, 32'hA5C3_0F81, 1'b0, 1'b0, 8'd1, 32'h0);
    do_frame(32'h0010_8000, 32'hFFFF_0001, 1'b0, 1'b1, 8'd2, 32'h0);
    do_frame(32'h0000_0010, 32'h0000_0000, 1'b1, 1'b1, 8'd0, 32'hA5C3_0F81);
    do_frame(32'h0010_8000, 32'h1234_5678, 1'b1, 1'b0, 8'd3, 32'h8000_0001);
    do_frame(32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1, 8'd1, 32'h0);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule